// File: doc/BRIEF.md
# Exclusive-Pair Atomic Update Engine

This block performs one atomic read-modify-write on a single memory word for a requester. It does not lock the bus. It reads the word with a load-exclusive, computes the new value, and writes it back with a store-exclusive. If the external monitor rejects the store, the engine starts again from the load. The memory and the exclusive monitor sit outside the block and are reached over a simple request/response port. A load-exclusive returns data; a store-exclusive returns one status bit.

A request carries a 4-bit opcode, an address and two operands. The supported operations are:
- arithmetic and logic operations, each in a fetch-then-op and an op-then-fetch form;
- a bit-clear;
- compare-and-swap, in a boolean form and a value form;
- a test-and-set lock acquire.

Only one operation is in flight at a time. A busy output holds off new requests until the response handshake completes. A configurable retry limit stops the engine from looping forever and reports an error flag instead.

Top module: `atom_rmw_engine`

## Requirements
- R1: Every operation starts with a load-exclusive (`mem_req_store`=0). A store-exclusive (`mem_req_store`=1) follows only after the load data has arrived. A store answered with `mem_rsp_fail`=1 restarts the sequence from a fresh load-exclusive, and the new value is recomputed from the newly loaded word.
- R2: With loaded word M and operand A (`req_opa`), the stored value is M+A, M−A, M|A, M&A, M^A or ~(M&A) for the low opcode bits 0,1,2,3,4,5. Opcode 6 stores M & ~A (bit-clear).
- R3: Opcodes 0–6 return the loaded word (fetch-then-op). Opcodes 8–13 apply the same operations as 0–5 and return the stored value (op-then-fetch).
- R4: For compare-and-swap (opcode 7 boolean form, opcode 15 value form), B (`req_opb`) is stored only if M equals A. On a mismatch no store-exclusive is issued and the engine responds at once.
- R5: Both compare-and-swap forms return M in `rsp_data`. `rsp_flag` is 1 when the compare matched and the store succeeded, and 0 on a mismatch.
- R6: Test-and-set (opcode 14) stores 1 only when M is 0. It then returns `rsp_flag`=1 and `rsp_data`=0. When M is nonzero it issues no store and returns `rsp_flag`=0 with `rsp_data`=M.
- R7: The response is raised only after the last store-exclusive succeeds, or after a no-store outcome. The returned value comes from the last iteration's load.
- R8: After MAX_RETRY consecutive failed store-exclusives, the engine responds with `rsp_err`=1, `rsp_flag`=0 and `rsp_data` equal to the last loaded word. With fewer failures it completes normally.
- R9: `busy` is high from acceptance until the response handshake. A request presented while `busy` is high is ignored.
- R10: `rsp_valid` and `rsp_data` stay stable until `rsp_ready` is high. The engine leaves `busy` only at that handshake.
- R11: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0.
- R12: A memory request holds its valid, kind, address and write data stable until `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Word address |
| req_opa | input | DW | Operand or compare value |
| req_opb | input | DW | Swap value for compare-and-swap |
| busy | output | 1 | An operation is in flight |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Returned word |
| rsp_flag | output | 1 | Compare/lock success |
| rsp_err | output | 1 | Retry limit reached |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_store | output | 1 | 0 load-exclusive, 1 store-exclusive |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | DW | Load data |
| mem_rsp_fail | input | 1 | Store-exclusive rejected |

## Verification
Every opcode is run against a memory model whose ready line stalls periodically. Operand values are chosen so that each operation gives a distinct result and the old and new values always differ; this separates the fetch-then-op and op-then-fetch forms. Compare-and-swap and test-and-set are each run with a matching and a non-matching word, and the bench counts the stores issued, which shows whether a store was wrongly issued on a mismatch. Injected store failures, each paired with an interfering write, show that the result is recomputed from the reloaded word. Runs with one less than the limit and exactly the limit of failures tell a late success apart from the error outcome.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [3:0] {
        OP_FADD  = 4'd0,
        OP_FSUB  = 4'd1,
        OP_FOR   = 4'd2,
        OP_FAND  = 4'd3,
        OP_FXOR  = 4'd4,
        OP_FNAND = 4'd5,
        OP_BIC   = 4'd6,
        OP_CASB  = 4'd7,
        OP_ADDF  = 4'd8,
        OP_SUBF  = 4'd9,
        OP_ORF   = 4'd10,
        OP_ANDF  = 4'd11,
        OP_XORF  = 4'd12,
        OP_NANDF = 4'd13,
        OP_TAS   = 4'd14,
        OP_CASV  = 4'd15
    } atom_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_REQ,
        ST_LD_WAIT,
        ST_ST_REQ,
        ST_ST_WAIT,
        ST_RESP
    } atom_state_e;

endpackage

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DW = 32
) (
    input  atom_op_e        op,
    input  logic [DW-1:0]   mem_val,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic [DW-1:0]   new_val,
    output logic            do_store,
    output logic            ret_new,
    output logic            cond_op
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        new_val  = mem_val;
        do_store = 1'b1;
        ret_new  = 1'b0;
        cond_op  = 1'b0;
        unique case (op)
            OP_FADD, OP_ADDF:   new_val = mem_val + opa;
            OP_FSUB, OP_SUBF:   new_val = mem_val - opa;
            OP_FOR, OP_ORF:     new_val = mem_val | opa;
            OP_FAND, OP_ANDF:   new_val = mem_val & opa;
            OP_FXOR, OP_XORF:   new_val = mem_val ^ opa;
            OP_FNAND, OP_NANDF: new_val = ~(mem_val & opa);
            OP_BIC:             new_val = mem_val & ~opa;
            OP_CASB, OP_CASV: begin
                new_val  = opb;
                do_store = (mem_val == opa);
                cond_op  = 1'b1;
            end
            OP_TAS: begin
                new_val  = ONE;
                do_store = (mem_val == '0);
                cond_op  = 1'b1;
            end
            default: new_val = mem_val;
        endcase
        if (op inside {OP_ADDF, OP_SUBF, OP_ORF, OP_ANDF, OP_XORF, OP_NANDF}) begin
            ret_new = 1'b1;
        end
    end

endmodule

// File: rtl/atom_retry_ctr.sv
module atom_retry_ctr #(
    parameter int MAX_RETRY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(MAX_RETRY + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_RETRY - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != LAST) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/atom_rmw_engine.sv
module atom_rmw_engine
    import atom_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int MAX_RETRY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [3:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_opa,
    input  logic [DW-1:0] req_opb,
    output logic          busy,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_flag,
    output logic          rsp_err,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_store,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    input  logic          mem_rsp_fail
);

    typedef struct packed {
        atom_state_e   st;
        atom_op_e      op;
        logic [AW-1:0] addr;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] old;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          flag;
        logic          err;
    } eng_regs_t;

    eng_regs_t d, q;

    logic [DW-1:0] alu_new;
    logic          alu_store;
    logic          alu_ret_new;
    logic          alu_cond;
    logic          ctr_clr;
    logic          ctr_inc;
    logic          ctr_limit;

    atom_alu #(.DW(DW)) u_alu (
        .op       (q.op),
        .mem_val  (mem_rsp_rdata),
        .opa      (q.opa),
        .opb      (q.opb),
        .new_val  (alu_new),
        .do_store (alu_store),
        .ret_new  (alu_ret_new),
        .cond_op  (alu_cond)
    );

    atom_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctr_clr),
        .inc      (ctr_inc),
        .at_limit (ctr_limit)
    );

    always_comb begin
        d       = q;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_LD_REQ;
                    d.op    = atom_op_e'(req_op);
                    d.addr  = req_addr;
                    d.opa   = req_opa;
                    d.opb   = req_opb;
                    d.flag  = 1'b0;
                    d.err   = 1'b0;
                    ctr_clr = 1'b1;
                end
            end
            ST_LD_REQ: begin
                if (mem_req_ready) d.st = ST_LD_WAIT;
            end
            ST_LD_WAIT: begin
                if (mem_rsp_valid) begin
                    d.old   = mem_rsp_rdata;
                    d.wdata = alu_new;
                    if (alu_store) begin
                        d.st = ST_ST_REQ;
                    end else begin
                        d.st    = ST_RESP;
                        d.rdata = mem_rsp_rdata;
                        d.flag  = 1'b0;
                    end
                end
            end
            ST_ST_REQ: begin
                if (mem_req_ready) d.st = ST_ST_WAIT;
            end
            ST_ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_fail) begin
                        d.st    = ST_RESP;
                        d.rdata = alu_ret_new ? q.wdata : q.old;
                        d.flag  = alu_cond;
                    end else if (ctr_limit) begin
                        d.st    = ST_RESP;
                        d.rdata = q.old;
                        d.flag  = 1'b0;
                        d.err   = 1'b1;
                    end else begin
                        d.st    = ST_LD_REQ;
                        ctr_inc = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_FADD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.st != ST_IDLE);
    assign rsp_valid     = (q.st == ST_RESP);
    assign rsp_data      = q.rdata;
    assign rsp_flag      = q.flag;
    assign rsp_err       = q.err;
    assign mem_req_valid = (q.st == ST_LD_REQ) || (q.st == ST_ST_REQ);
    assign mem_req_store = (q.st == ST_ST_REQ);
    assign mem_req_addr  = q.addr;
    assign mem_req_wdata = q.wdata;

endmodule

// File: rtl/atom_rmw_checker.sv
module atom_rmw_checker #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [DW-1:0] rsp_data,
    input logic          rsp_flag,
    input logic          rsp_err,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_store,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_wdata
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_store)
        && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R12

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
        && $stable(rsp_flag) && $stable(rsp_err)); // R10

    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !rsp_valid); // R9

    AST_NO_REQ_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid); // R7

    AST_ERR_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> !rsp_flag); // R8

endmodule

bind atom_rmw_engine atom_rmw_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_flag      (rsp_flag),
    .rsp_err       (rsp_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_store (mem_req_store),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/atom_rmw_engine_tb.sv
`timescale 1ns/1ps
module atom_rmw_engine_tb;

    localparam int DW = 32;
    localparam int AW = 8;

    typedef struct packed {
        logic [3:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] init;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [3:0]    nfail;
        logic [DW-1:0] exp_data;
        logic          exp_flag;
        logic          exp_err;
        logic [DW-1:0] exp_mem;
        logic [3:0]    exp_st;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'd1, 32'd10,       32'd5,        32'd0, 4'd0, 32'd10,       1'b0, 1'b0, 32'd15,       4'd1},
        '{4'd8,  8'd2, 32'd10,       32'd5,        32'd0, 4'd0, 32'd15,       1'b0, 1'b0, 32'd15,       4'd1},
        '{4'd1,  8'd3, 32'd3,        32'd5,        32'd0, 4'd0, 32'd3,        1'b0, 1'b0, 32'hFFFFFFFE, 4'd1},
        '{4'd9,  8'd4, 32'd100,      32'd1,        32'd0, 4'd0, 32'd99,       1'b0, 1'b0, 32'd99,       4'd1},
        '{4'd2,  8'd5, 32'hF0,       32'h0F,       32'd0, 4'd0, 32'hF0,       1'b0, 1'b0, 32'hFF,       4'd1},
        '{4'd11, 8'd6, 32'hF0,       32'h3C,       32'd0, 4'd0, 32'h30,       1'b0, 1'b0, 32'h30,       4'd1},
        '{4'd4,  8'd7, 32'hFF00,     32'h0FF0,     32'd0, 4'd0, 32'hFF00,     1'b0, 1'b0, 32'hF0F0,     4'd1},
        '{4'd13, 8'd8, 32'hFFFF0000, 32'hFF00FF00, 32'd0, 4'd0, 32'h00FFFFFF, 1'b0, 1'b0, 32'h00FFFFFF, 4'd1},
        '{4'd6,  8'd9, 32'hFF,       32'h0F,       32'd0, 4'd0, 32'hFF,       1'b0, 1'b0, 32'hF0,       4'd1},
        '{4'd7,  8'd1, 32'd7,        32'd7,        32'd9, 4'd0, 32'd7,        1'b1, 1'b0, 32'd9,        4'd1},
        '{4'd7,  8'd2, 32'd8,        32'd7,        32'd9, 4'd0, 32'd8,        1'b0, 1'b0, 32'd8,        4'd0},
        '{4'd15, 8'd3, 32'd42,       32'd42,       32'd1, 4'd0, 32'd42,       1'b1, 1'b0, 32'd1,        4'd1},
        '{4'd15, 8'd4, 32'd5,        32'd6,        32'd1, 4'd0, 32'd5,        1'b0, 1'b0, 32'd5,        4'd0},
        '{4'd14, 8'd5, 32'd0,        32'd0,        32'd0, 4'd0, 32'd0,        1'b1, 1'b0, 32'd1,        4'd1},
        '{4'd14, 8'd6, 32'd1,        32'd0,        32'd0, 4'd0, 32'd1,        1'b0, 1'b0, 32'd1,        4'd0},
        '{4'd0,  8'd7, 32'd10,       32'd5,        32'd0, 4'd2, 32'h20A,      1'b0, 1'b0, 32'h20F,      4'd3},
        '{4'd7,  8'd8, 32'd7,        32'd7,        32'd9, 4'd1, 32'h107,      1'b0, 1'b0, 32'h107,      4'd1},
        '{4'd8,  8'd9, 32'd1,        32'd1,        32'd0, 4'd3, 32'h302,      1'b0, 1'b0, 32'h302,      4'd4},
        '{4'd0,  8'd1, 32'd1,        32'd1,        32'd0, 4'd4, 32'h301,      1'b0, 1'b1, 32'h401,      4'd4},
        '{4'd14, 8'd2, 32'd0,        32'd0,        32'd0, 4'd1, 32'h100,      1'b0, 1'b0, 32'h100,      4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0;
    logic [DW-1:0] req_opb = '0;
    logic          busy;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [DW-1:0] rsp_data;
    logic          rsp_flag;
    logic          rsp_err;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic          mem_req_store;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_rdata;
    logic          mem_rsp_fail;

    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_init = '0;
    logic [3:0]    cfg_fail = '0;
    logic [DW-1:0] mem [16];
    logic [3:0]    fail_left;
    logic [3:0]    st_cnt;
    logic [31:0]   cyc;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    atom_rmw_engine #(.DW(DW), .AW(AW), .MAX_RETRY(4)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_opa       (req_opa),
        .req_opb       (req_opb),
        .busy          (busy),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_data      (rsp_data),
        .rsp_flag      (rsp_flag),
        .rsp_err       (rsp_err),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_store (mem_req_store),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .mem_rsp_fail  (mem_rsp_fail)
    );

    // Memory and monitor model: a failed store stands for another writer adding 0x100.
    assign mem_req_ready = (cyc % 3) != 2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            fail_left     <= '0;
            st_cnt        <= '0;
            cyc           <= '0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
            mem_rsp_fail  <= 1'b0;
        end else begin
            cyc           <= cyc + 1;
            mem_rsp_valid <= 1'b0;
            if (cfg_load) begin
                mem[cfg_addr[3:0]] <= cfg_init;
                fail_left          <= cfg_fail;
                st_cnt             <= '0;
            end else if (mem_req_valid && mem_req_ready) begin
                mem_rsp_valid <= 1'b1;
                if (!mem_req_store) begin
                    mem_rsp_rdata <= mem[mem_req_addr[3:0]];
                    mem_rsp_fail  <= 1'b0;
                end else begin
                    st_cnt        <= st_cnt + 1;
                    mem_rsp_rdata <= '0;
                    if (fail_left != 0) begin
                        fail_left                <= fail_left - 1;
                        mem_rsp_fail             <= 1'b1;
                        mem[mem_req_addr[3:0]]   <= mem[mem_req_addr[3:0]] + 32'h100;
                    end else begin
                        mem_rsp_fail             <= 1'b0;
                        mem[mem_req_addr[3:0]]   <= mem_req_wdata;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [AW-1:0] a, input logic [DW-1:0] v, input logic [3:0] nf);
        @(negedge clk);
        cfg_addr = a; cfg_init = v; cfg_fail = nf; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_rsp(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (rsp_valid) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) chk("R7 response timeout", 32'd0, 32'd1);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit ok;
        setup(v.addr, v.init, v.nfail);
        req_op = v.op; req_addr = v.addr; req_opa = v.opa; req_opb = v.opb;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(ok);
        if (ok) begin
            chk($sformatf("R3/R5/R7 vec%0d data", idx), rsp_data, v.exp_data);
            chk($sformatf("R5/R6 vec%0d flag", idx), DW'(rsp_flag), DW'(v.exp_flag));
            chk($sformatf("R8 vec%0d err", idx), DW'(rsp_err), DW'(v.exp_err));
            @(negedge clk);
            chk($sformatf("R1/R2 vec%0d mem", idx), mem[v.addr[3:0]], v.exp_mem);
            chk($sformatf("R1/R4 vec%0d stores", idx), DW'(st_cnt), DW'(v.exp_st));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", DW'(busy), 32'd0);
        chk("R11 rsp_valid", DW'(rsp_valid), 32'd0);
        chk("R11 mem_req_valid", DW'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R9: a request while busy is ignored
        setup(8'd10, 32'd0, 4'd0);
        req_op = 4'd0; req_addr = 8'd10; req_opa = 32'd1; req_valid = 1'b1;
        @(negedge clk);
        chk("R9 busy after accept", DW'(busy), 32'd1);
        req_opa = 32'd50; req_op = 4'd8;
        wait_rsp(ok);
        req_valid = 1'b0;
        if (ok) chk("R9 data of first op", rsp_data, 32'd0);
        repeat (2) @(negedge clk);
        chk("R9 only one update", mem[10], 32'd1);
        chk("R9 store count", DW'(st_cnt), 32'd1);

        // R10: response held until accepted
        setup(8'd11, 32'd20, 4'd0);
        rsp_ready = 1'b0;
        req_op = 4'd9; req_addr = 8'd11; req_opa = 32'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(ok);
        held = rsp_data;
        chk("R10 data", held, 32'd16);
        repeat (4) begin
            @(negedge clk);
            chk("R10 valid held", DW'(rsp_valid), 32'd1);
            chk("R10 busy held", DW'(busy), 32'd1);
            chk("R10 data held", rsp_data, held);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R10 busy released", DW'(busy), 32'd0);
        chk("R10 valid released", DW'(rsp_valid), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule